// File: doc/BRIEF.md
# Paged Address Translation Unit

The block maps a 32-bit virtual address to a 30-bit physical address for one requester. It keeps a 16-entry, 4-way set-associative cache of page table entries tagged by virtual page number and process ID. Each lookup also applies the page's read, write, execute and supervisor-only permissions to the access type and privilege level of the request. The low 12 bits of the address are the page offset and pass through unchanged.

When the cache misses, a built-in walker reads one 32-bit entry from a single-level page table in memory. The entry's address is the table base input plus four times the virtual page number. The walker stores a valid entry in the cache and then answers. A page number at or above the table limit input is refused with a limit fault, and no memory read is made. A request is taken when `req_valid_i` and `req_ready_o` are both high. A hit answers one cycle later. A miss holds `req_ready_o` low until the walk is done. A flush input clears every cached entry.

Top module: `mmu_xlate`

## Requirements
- R1: A response with no fault has `rsp_pa_o` = {PFN, va[11:0]}. A response with a fault has `rsp_pa_o` = 0. Fault codes: 0 none, 1 page fault, 2 limit fault, 3 protection fault.
- R2: A request that hits answers with `rsp_valid_o` high in the cycle after it is accepted, and no memory read takes place.
- R3: The cache set is VPN[1:0]. The tag is the process ID together with VPN[19:2]. The same VPN under a different process ID misses.
- R4: On a miss, `mem_req_o` stays high with `mem_addr_o` = base + 4*VPN until `mem_ack_i` is sampled. The response follows in the next cycle. `req_ready_o` is low for the whole walk.
- R5: The page table entry has bit0 valid, bit1 read, bit2 write, bit3 execute, bit4 supervisor-only, bit5 dirty and bits 23:6 PFN. A fetched entry with bit0 = 0 gives a page fault, and the entry is not cached, so a repeat of the request walks again.
- R6: A miss whose VPN is at or above `ptlr_i` answers with a limit fault in the next cycle and reads no memory. VPN = `ptlr_i`-1 is walked normally.
- R7: Access codes are 0 read, 1 write, 2 execute and 3 none. An access is refused with a protection fault when its permission bit is clear, when the code is 3, or when a user request (`req_user_i`=1) touches a supervisor-only page.
- R8: `rsp_dirty_o` gives the entry's dirty bit after the access. A permitted write, whether it hits or is filled, sets the bit. A read, or a refused write, leaves it unchanged.
- R9: A fill goes to the lowest invalid way of its set. When the set is full, the fill goes to the way named by that set's round-robin pointer. The pointer starts at 0 and advances by one on each such replacement.
- R10: A one-cycle pulse on `flush_i` invalidates every entry. A request accepted in the same cycle as the flush is treated as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all cached entries |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_va_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 none |
| req_user_i | input | 1 | 1 = user level, 0 = supervisor |
| req_pid_i | input | 4 | Process ID |
| ptbr_i | input | 30 | Page table base physical address |
| ptlr_i | input | 20 | Page table limit, as a number of pages |
| mem_req_o | output | 1 | Page table read request |
| mem_addr_o | output | 30 | Page table read address |
| mem_ack_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Page table entry read |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_pa_o | output | 30 | Physical address |
| rsp_fault_o | output | 2 | Fault code |
| rsp_dirty_o | output | 1 | Dirty bit of the entry after the access |

## Verification
Two events can land on the same clock edge: a flush, and a lookup that would otherwise hit. The bench raises `flush_i` during the acceptance cycle of a request whose page is known to be cached. It passes that case only if a page table read follows, and only if an identical request afterwards hits again with no read. A second pair is a permitted write hit setting the dirty bit in the same step as its permission check. That case is judged through `rsp_dirty_o` on the write and on the read that follows, and against a refused write that must leave the bit clear.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int VA_W        = 32;
  localparam int PAGE_W      = 12;
  localparam int PA_W        = 30;
  localparam int PID_W       = 4;
  localparam int ENTRIES     = 16;
  localparam int WAYS        = 4;
  localparam int PTE_W       = 32;
  localparam int PTE_PFN_LSB = 6;

  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int PFN_W  = PA_W - PAGE_W;
  localparam int SETS   = ENTRIES / WAYS;
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = PID_W + VPN_W - IDX_W;
  localparam int PTE_SH = $clog2(PTE_W / 8);

  typedef enum logic [1:0] {ACC_READ, ACC_WRITE, ACC_EXEC, ACC_NONE} acc_e;
  typedef enum logic [1:0] {FLT_NONE, FLT_PAGE, FLT_LIMIT, FLT_PROT} flt_e;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             r;
    logic             w;
    logic             x;
    logic             s;
    logic             d;
    logic [PFN_W-1:0] pfn;
  } ent_t;
endpackage

// File: rtl/mmu_perm.sv
module mmu_perm
  import mmu_pkg::*;
(
  input  logic [1:0] acc_i,
  input  logic       user_i,
  input  logic       r_i,
  input  logic       w_i,
  input  logic       x_i,
  input  logic       s_i,
  output logic       ok_o
);
  always_comb begin
    unique case (acc_i)
      ACC_READ:  ok_o = r_i;
      ACC_WRITE: ok_o = w_i;
      ACC_EXEC:  ok_o = x_i;
      default:   ok_o = 1'b0;
    endcase
    if (user_i && s_i) ok_o = 1'b0;
  end
endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb
  import mmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  output logic [WAY_W-1:0] lk_way_o,
  output ent_t             lk_ent_o,
  input  logic             dset_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  ent_t             fill_ent_i
);
  logic [SETS-1:0][WAYS-1:0]  vld_q;
  ent_t [SETS-1:0][WAYS-1:0]  ent_q;
  logic [SETS-1:0][WAY_W-1:0] rr_q;
  logic [WAYS-1:0]            hit_vec;
  logic [WAY_W-1:0]           vic;
  logic                       use_rr;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[lk_idx_i][w] && (ent_q[lk_idx_i][w].tag == lk_tag_i);
  end

  // a flush in the lookup cycle turns the lookup into a miss
  assign lk_hit_o = (|hit_vec) && !flush_i;

  always_comb begin
    lk_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) lk_way_o = WAY_W'(w);
  end
  assign lk_ent_o = ent_q[lk_idx_i][lk_way_o];

  // lowest invalid way, else round-robin pointer
  always_comb begin
    vic    = rr_q[fill_idx_i];
    use_rr = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[fill_idx_i][w]) begin
        vic    = WAY_W'(w);
        use_rr = 1'b0;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (fill_i) begin
      vld_q[fill_idx_i][vic] <= 1'b1;
      if (use_rr) rr_q[fill_idx_i] <= rr_q[fill_idx_i] + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) ent_q[fill_idx_i][vic] <= fill_ent_i;
    if (dset_i) ent_q[lk_idx_i][lk_way_o].d <= 1'b1;
  end
endmodule

// File: rtl/mmu_walk.sv
module mmu_walk
  import mmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [1:0]       acc_i,
  input  logic             user_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic             ack_i,
  output logic             busy_o,
  output logic [PA_W-1:0]  addr_o,
  output logic             done_o,
  output logic [VA_W-1:0]  va_o,
  output logic [1:0]       acc_o,
  output logic             user_o,
  output logic [PID_W-1:0] pid_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      va_o   <= '0;
      acc_o  <= '0;
      user_o <= 1'b0;
      pid_o  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      va_o   <= va_i;
      acc_o  <= acc_i;
      user_o <= user_i;
      pid_o  <= pid_i;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && ack_i;
  assign addr_o = base_i + (PA_W'(va_o[VA_W-1:PAGE_W]) << PTE_SH);
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic [1:0]       req_acc_i,
  input  logic             req_user_i,
  input  logic [PID_W-1:0] req_pid_i,
  input  logic [PA_W-1:0]  ptbr_i,
  input  logic [VPN_W-1:0] ptlr_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic [1:0]       rsp_fault_o,
  output logic             rsp_dirty_o
);
  logic [VPN_W-1:0] req_vpn, wk_vpn;
  logic             accept, hit, hit_ok, beyond, start;
  logic [WAY_W-1:0] hit_way;
  ent_t             hit_ent, new_ent;
  logic             wk_busy, wk_done, wk_user, wk_ok, pte_v, fill, dset;
  logic [VA_W-1:0]  wk_va;
  logic [1:0]       wk_acc;
  logic [PID_W-1:0] wk_pid;
  logic             unused_pte;
  logic [WAY_W-1:0] unused_way;

  assign req_vpn     = req_va_i[VA_W-1:PAGE_W];
  assign wk_vpn      = wk_va[VA_W-1:PAGE_W];
  assign req_ready_o = !wk_busy;
  assign accept      = req_valid_i && req_ready_o;
  assign beyond      = req_vpn >= ptlr_i;
  assign start       = accept && !hit && !beyond;
  assign dset        = accept && hit && hit_ok && (req_acc_i == ACC_WRITE);
  assign unused_pte  = ^mem_rdata_i[PTE_W-1:PTE_PFN_LSB+PFN_W];
  assign unused_way  = hit_way;

  mmu_tlb u_tlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .lk_idx_i   (req_vpn[IDX_W-1:0]),
    .lk_tag_i   ({req_pid_i, req_vpn[VPN_W-1:IDX_W]}),
    .lk_hit_o   (hit),
    .lk_way_o   (hit_way),
    .lk_ent_o   (hit_ent),
    .dset_i     (dset),
    .fill_i     (fill),
    .fill_idx_i (wk_vpn[IDX_W-1:0]),
    .fill_ent_i (new_ent)
  );

  mmu_perm u_perm_hit (
    .acc_i  (req_acc_i),
    .user_i (req_user_i),
    .r_i    (hit_ent.r),
    .w_i    (hit_ent.w),
    .x_i    (hit_ent.x),
    .s_i    (hit_ent.s),
    .ok_o   (hit_ok)
  );

  mmu_walk u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .va_i   (req_va_i),
    .acc_i  (req_acc_i),
    .user_i (req_user_i),
    .pid_i  (req_pid_i),
    .base_i (ptbr_i),
    .ack_i  (mem_ack_i),
    .busy_o (wk_busy),
    .addr_o (mem_addr_o),
    .done_o (wk_done),
    .va_o   (wk_va),
    .acc_o  (wk_acc),
    .user_o (wk_user),
    .pid_o  (wk_pid)
  );
  assign mem_req_o = wk_busy;

  mmu_perm u_perm_walk (
    .acc_i  (wk_acc),
    .user_i (wk_user),
    .r_i    (mem_rdata_i[1]),
    .w_i    (mem_rdata_i[2]),
    .x_i    (mem_rdata_i[3]),
    .s_i    (mem_rdata_i[4]),
    .ok_o   (wk_ok)
  );

  assign pte_v = mem_rdata_i[0];
  assign fill  = wk_done && pte_v;

  always_comb begin
    new_ent.tag = {wk_pid, wk_vpn[VPN_W-1:IDX_W]};
    new_ent.r   = mem_rdata_i[1];
    new_ent.w   = mem_rdata_i[2];
    new_ent.x   = mem_rdata_i[3];
    new_ent.s   = mem_rdata_i[4];
    new_ent.d   = mem_rdata_i[5] || (wk_ok && (wk_acc == ACC_WRITE));
    new_ent.pfn = mem_rdata_i[PTE_PFN_LSB +: PFN_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_pa_o    <= '0;
      rsp_fault_o <= FLT_NONE;
      rsp_dirty_o <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (accept && hit) begin
        rsp_valid_o <= 1'b1;
        rsp_pa_o    <= hit_ok ? {hit_ent.pfn, req_va_i[PAGE_W-1:0]} : '0;
        rsp_fault_o <= hit_ok ? FLT_NONE : FLT_PROT;
        rsp_dirty_o <= hit_ent.d || dset;
      end else if (accept && beyond) begin
        rsp_valid_o <= 1'b1;
        rsp_pa_o    <= '0;
        rsp_fault_o <= FLT_LIMIT;
        rsp_dirty_o <= 1'b0;
      end else if (wk_done) begin
        rsp_valid_o <= 1'b1;
        if (!pte_v) begin
          rsp_pa_o    <= '0;
          rsp_fault_o <= FLT_PAGE;
          rsp_dirty_o <= 1'b0;
        end else begin
          rsp_pa_o    <= wk_ok ? {new_ent.pfn, wk_va[PAGE_W-1:0]} : '0;
          rsp_fault_o <= wk_ok ? FLT_NONE : FLT_PROT;
          rsp_dirty_o <= new_ent.d;
        end
      end
    end
  end
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk
  import mmu_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [VA_W-1:0]  req_va_i,
  input logic [1:0]       req_acc_i,
  input logic             req_user_i,
  input logic [PID_W-1:0] req_pid_i,
  input logic [PA_W-1:0]  ptbr_i,
  input logic [VPN_W-1:0] ptlr_i,
  input logic             mem_req_o,
  input logic [PA_W-1:0]  mem_addr_o,
  input logic             mem_ack_i,
  input logic [PTE_W-1:0] mem_rdata_i,
  input logic             rsp_valid_o,
  input logic [PA_W-1:0]  rsp_pa_o,
  input logic [1:0]       rsp_fault_o,
  input logic             rsp_dirty_o
);
  logic take;
  logic unused_chk;
  assign take = req_valid_i && req_ready_o;
  assign unused_chk = ^{req_acc_i, req_user_i, req_pid_i, ptbr_i, mem_rdata_i, rsp_dirty_o};

  AST_FAULT_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 2'd0) |-> (rsp_pa_o == '0)); // R1
  AST_TAKE_ANSWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (rsp_valid_o || mem_req_o)); // R2
  AST_WALK_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o); // R4
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R4
  AST_ACK_ANSWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> (rsp_valid_o && !mem_req_o)); // R4
  AST_LIMIT_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && req_va_i[VA_W-1:PAGE_W] >= ptlr_i) |=> (rsp_valid_o && !mem_req_o)); // R6
  AST_FLUSH_MISSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && flush_i) |=> (mem_req_o || (rsp_valid_o && rsp_fault_o == 2'd2))); // R10
endmodule

bind mmu_xlate mmu_xlate_chk u_mmu_xlate_chk (.*);

// File: tb/mmu_xlate_bench.sv
`timescale 1ns/1ps
module mmu_xlate_bench;
  localparam logic [29:0] BASE  = 30'h0100_0000;
  localparam logic [19:0] LIMIT = 20'hA0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic [3:0]  req_pid = '0;
  logic        mem_req;
  logic [29:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [29:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic        rsp_dirty;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int wcnt   = 0;

  always #2 clk = ~clk;

  mmu_xlate u_mmu_xlate (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_acc_i(req_acc), .req_user_i(req_user), .req_pid_i(req_pid),
    .ptbr_i(BASE), .ptlr_i(LIMIT),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault), .rsp_dirty_o(rsp_dirty)
  );

  // page table contents by VPN[19:16]: 0 RW, 1 R, 2 X, 3 RW supervisor, 4 RW dirty, 5 invalid, other RW
  function automatic logic [31:0] pte_of(logic [19:0] vpn);
    logic [5:0] f;
    case (vpn[19:16])
      4'h0: f = 6'b000111;
      4'h1: f = 6'b000011;
      4'h2: f = 6'b001001;
      4'h3: f = 6'b010111;
      4'h4: f = 6'b100111;
      4'h5: f = 6'b000000;
      default: f = 6'b000111;
    endcase
    return {8'h00, vpn[17:0] ^ 18'h2A5A5, f};
  endfunction

  function automatic logic [1:0] exp_fault(logic [19:0] vpn, logic [1:0] acc, logic user);
    logic [31:0] p;
    logic ok;
    p = pte_of(vpn);
    if (vpn >= LIMIT) return 2'd2;
    if (!p[0]) return 2'd1;
    case (acc)
      2'd0: ok = p[1];
      2'd1: ok = p[2];
      2'd2: ok = p[3];
      default: ok = 1'b0;
    endcase
    if (user && p[4]) ok = 1'b0;
    return ok ? 2'd0 : 2'd3;
  endfunction

  // memory model: acknowledge on the second cycle of a request
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wcnt == 1) begin
        mem_ack   <= 1'b1;
        mem_rdata <= pte_of(20'((mem_addr - BASE) >> 2));
        wcnt      <= 0;
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic walked;
  int   lat;

  task automatic xlate(input logic [31:0] va, input logic [1:0] acc, input logic user,
                       input logic [3:0] pid, input logic fl);
    logic seen;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc; req_user = user; req_pid = pid; flush = fl;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b0;
    lat = 1; seen = 1'b0;
    while (!rsp_valid) begin
      if (mem_req && !seen) begin
        seen = 1'b1;
        chk(mem_addr == BASE + {va[31:12], 2'b00}, "R4 walk address", 32'(mem_addr),
            32'(BASE + {va[31:12], 2'b00}));
        chk(!req_ready, "R4 ready low in walk", 32'(req_ready), 0);
      end
      @(negedge clk);
      lat++;
    end
    walked = seen;
  endtask

  // check fault and PA against the page table model
  task automatic chk_result(input logic [31:0] va, input logic [1:0] acc, input logic user);
    logic [1:0]  ef;
    logic [29:0] ep;
    string       tag;
    ef = exp_fault(va[31:12], acc, user);
    ep = (ef == 2'd0) ? {pte_of(va[31:12])[23:6], va[11:0]} : 30'd0;
    case (ef)
      2'd1: tag = "R5 fault";
      2'd2: tag = "R6 fault";
      2'd3: tag = "R7 fault";
      default: tag = "R1 fault";
    endcase
    chk(rsp_fault == ef, tag, 32'(rsp_fault), 32'(ef));
    chk(rsp_pa == ep, "R1 pa", 32'(rsp_pa), 32'(ep));
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic        user;
    logic [3:0]  pid;
    logic        walk;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{32'h00010_123, 2'd0, 1'b0, 4'd1, 1'b1}, // R4 fill
    '{32'h00010_FFF, 2'd1, 1'b1, 4'd1, 1'b0}, // R2 hit
    '{32'h10011_004, 2'd1, 1'b0, 4'd1, 1'b1}, // R7 no write
    '{32'h10011_ABC, 2'd0, 1'b0, 4'd1, 1'b0}, // R2
    '{32'h20012_010, 2'd2, 1'b1, 4'd1, 1'b1}, // R7 execute
    '{32'h20012_020, 2'd0, 1'b0, 4'd1, 1'b0}, // R7 no read
    '{32'h30013_000, 2'd0, 1'b1, 4'd1, 1'b1}, // R7 supervisor page
    '{32'h30013_555, 2'd0, 1'b0, 4'd1, 1'b0}, // R7
    '{32'h50010_000, 2'd0, 1'b0, 4'd1, 1'b1}, // R5
    '{32'h50010_000, 2'd0, 1'b0, 4'd1, 1'b1}, // R5 not cached
    '{32'h00010_321, 2'd0, 1'b0, 4'd2, 1'b1}, // R3 other pid
    '{32'h00010_321, 2'd0, 1'b0, 4'd1, 1'b0}, // R3
    '{32'hA0000_000, 2'd0, 1'b0, 4'd1, 1'b0}, // R6 at limit
    '{32'h9FFFF_777, 2'd0, 1'b0, 4'd1, 1'b1}  // R6 below limit
  };

  task automatic chk_walk(input logic exp, input string tag);
    chk(walked == exp, tag, 32'(walked), 32'(exp));
    if (!exp) chk(lat == 1, "R2 latency", 32'(lat), 1);
  endtask

  initial begin
    #1;
    chk(rsp_valid == 1'b0, "R2 reset rsp_valid", 32'(rsp_valid), 0);
    chk(mem_req == 1'b0, "R4 reset mem_req", 32'(mem_req), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R4 ready after reset", 32'(req_ready), 1);

    foreach (VECS[i]) begin
      xlate(VECS[i].va, VECS[i].acc, VECS[i].user, VECS[i].pid, 1'b0);
      chk_walk(VECS[i].walk, $sformatf("R2 walk vec %0d", i));
      chk_result(VECS[i].va, VECS[i].acc, VECS[i].user);
    end

    // R8 dirty tracking
    xlate(32'h00020_000, 2'd0, 1'b0, 4'd1, 1'b0);
    chk_walk(1'b1, "R8 fill");
    chk(rsp_dirty == 1'b0, "R8 clean read", 32'(rsp_dirty), 0);
    xlate(32'h00020_004, 2'd1, 1'b0, 4'd1, 1'b0);
    chk_walk(1'b0, "R8 write hit");
    chk(rsp_dirty == 1'b1, "R8 write hit sets", 32'(rsp_dirty), 1);
    xlate(32'h00020_008, 2'd0, 1'b0, 4'd1, 1'b0);
    chk(rsp_dirty == 1'b1, "R8 read keeps", 32'(rsp_dirty), 1);
    xlate(32'h40024_000, 2'd0, 1'b0, 4'd1, 1'b0);
    chk(rsp_dirty == 1'b1, "R8 dirty in entry", 32'(rsp_dirty), 1);
    xlate(32'h00021_000, 2'd1, 1'b0, 4'd1, 1'b0);
    chk_walk(1'b1, "R8 write fill");
    chk(rsp_dirty == 1'b1, "R8 write fill sets", 32'(rsp_dirty), 1);
    xlate(32'h10011_000, 2'd1, 1'b0, 4'd1, 1'b0);
    chk(rsp_fault == 2'd3, "R8 refused write", 32'(rsp_fault), 3);
    chk(rsp_dirty == 1'b0, "R8 refused write clean", 32'(rsp_dirty), 0);

    // R9 set 0 is full: ways hold p1 0x10, p2 0x10, 0x20, 0x40024
    xlate(32'h00030_000, 2'd0, 1'b0, 4'd1, 1'b0);
    chk_walk(1'b1, "R9 fill full set");
    xlate(32'h00010_000, 2'd0, 1'b0, 4'd1, 1'b0);
    chk_walk(1'b1, "R9 way 0 evicted");
    xlate(32'h00020_000, 2'd0, 1'b0, 4'd1, 1'b0);
    chk_walk(1'b0, "R9 way 2 kept");
    chk(rsp_dirty == 1'b1, "R9 kept entry dirty", 32'(rsp_dirty), 1);
    xlate(32'h40024_000, 2'd0, 1'b0, 4'd1, 1'b0);
    chk_walk(1'b0, "R9 way 3 kept");
    xlate(32'h00030_000, 2'd0, 1'b0, 4'd1, 1'b0);
    chk_walk(1'b0, "R9 new entry kept");
    xlate(32'h00010_000, 2'd0, 1'b0, 4'd2, 1'b0);
    chk_walk(1'b1, "R9 way 1 evicted second");

    // R10 flush in the same cycle as a request that would hit
    xlate(32'h20012_000, 2'd2, 1'b1, 4'd1, 1'b1);
    chk_walk(1'b1, "R10 flush with request");
    chk_result(32'h20012_000, 2'd2, 1'b1);
    xlate(32'h20012_000, 2'd2, 1'b1, 4'd1, 1'b0);
    chk_walk(1'b0, "R10 refilled");

    // R10 flush alone
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    xlate(32'h00030_000, 2'd0, 1'b0, 4'd1, 1'b0);
    chk_walk(1'b1, "R10 flush clears");
    xlate(32'h00020_000, 2'd0, 1'b0, 4'd1, 1'b0);
    chk(rsp_dirty == 1'b0, "R10 refetched clean", 32'(rsp_dirty), 0);

    // R7 access code 3
    xlate(32'h00020_000, 2'd3, 1'b0, 4'd1, 1'b0);
    chk(rsp_fault == 2'd3, "R7 access none", 32'(rsp_fault), 3);

    finish_run();
  end
endmodule